// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block runs one complete SMBus transaction each time software starts it. Software stages the slave address with its direction bit, a command byte, up to two data bytes or a block of up to 32 bytes, and a protocol code. It then sets the start bit. A sequencer walks the protocol's byte sequence over a byte-level bus-master interface and reports the outcome as sticky status flags, which software clears by writing one to them. An optional interrupt fires when a flag is set.

The downstream side carries four primitives: start (which also serves as a repeated start), write a byte, read a byte and stop. Each primitive is held until the bus master pulses `bm_done`. With that pulse the bus master returns the acknowledge, lost arbitration, timeout and received data. Bit-level line timing, packet error checking and slave-side reception are outside this block.

Top module: `smb_host_ctrl`

## Requirements
- R1: Register offsets are status=0, control=1, command=2, address=3, data0=4, data1=5, block port=6, and any other offset reads 0. After reset every register, flag and `irq` is 0 and `bm_valid` is low.
- R2: Control bits are [4:0] protocol, [5] kill, [6] start and [7] interrupt enable. Status bit 0 (busy) reads 1 from the cycle after a start write until the transaction ends. While busy, writes to control (other than kill), command, address, data and the block port are ignored.
- R3: Status bits [1] done, [2] device error, [3] collision and [4] failed are cleared by writing one to them. All four are cleared when a transaction starts, and exactly one of them is set when it ends.
- R4: `bm_op` encodes start=0, write=1, read=2 and stop=3. Protocol 0 (quick) issues start, writes the address register unchanged, then stops.
- R5: With protocol 1 and address bit 0 clear, the block sends the command register after the address. With address bit 0 set, it reads one byte (flagged last) into data0.
- R6: Protocols 2 (byte) and 3 (word) write the command and then data0 (and data1). When reading, they write the command and issue a repeated start. They then send the address with bit 0 set and read into data0, then data1, with `bm_last` on the final read.
- R7: A protocol 4 write sends the command, then the count from data0, then that many buffer bytes. A count of 0 or more than 32 ends with device error and no bus activity.
- R8: A protocol 4 read stores the first read byte into data0 as the count and the following bytes into the buffer. A count of 0 or more than 32 ends with device error after a stop.
- R9: Each block-port write or read moves the buffer index up by one. Reading the control register resets the index to 0.
- R10: A missing acknowledge on any written byte, or a bus timeout, sets device error, and the transaction then ends with a stop.
- R11: Lost arbitration sets collision and ends the transaction with no stop.
- R12: Protocol codes 5 to 31 set device error without any bus activity.
- R13: Kill during a transaction sets failed, and the next primitive issued is a stop.
- R14: `irq` is high exactly while interrupt enable is set and any of the four flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on index) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| bm_valid | output | 1 | Primitive request, held until done |
| bm_op | output | 2 | Primitive code |
| bm_wbyte | output | 8 | Byte to write |
| bm_last | output | 1 | Final read byte, to be not acknowledged |
| bm_done | input | 1 | Primitive finished (one-cycle pulse) |
| bm_ack | input | 1 | Written byte acknowledged |
| bm_lost | input | 1 | Arbitration lost |
| bm_tmo | input | 1 | Bus timeout |
| bm_rdata | input | 8 | Byte received by a read |

## Verification
The bench targets the byte ordering of each protocol. A design that forgets the repeated start, or sends the read address with bit 0 clear, leaves a primitive log that does not match. The count bounds are probed at 0 and 33 for block writes and block reads. A design that is off by one there either touches the bus or accepts a bad count. Lost arbitration is checked for the missing stop, and kill for an immediate stop with failed set. Writes made while busy are read back to prove they were dropped, and a control read is used to show the buffer index returning to zero.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam logic [2:0] REG_STATUS = 3'd0;
    localparam logic [2:0] REG_CTRL   = 3'd1;
    localparam logic [2:0] REG_CMD    = 3'd2;
    localparam logic [2:0] REG_ADDR   = 3'd3;
    localparam logic [2:0] REG_DATA0  = 3'd4;
    localparam logic [2:0] REG_DATA1  = 3'd5;
    localparam logic [2:0] REG_BLOCK  = 3'd6;

    localparam logic [4:0] PR_QUICK = 5'd0;
    localparam logic [4:0] PR_BYTE  = 5'd1;
    localparam logic [4:0] PR_BDATA = 5'd2;
    localparam logic [4:0] PR_WDATA = 5'd3;
    localparam logic [4:0] PR_BLOCK = 5'd4;

    typedef enum logic [1:0] {BM_START = 2'd0, BM_WRITE = 2'd1, BM_READ = 2'd2, BM_STOP = 2'd3} bm_op_e;
    typedef enum logic [1:0] {RES_DONE, RES_DEVERR, RES_COLL, RES_FAIL} result_e;
    typedef enum logic [3:0] {PH_START, PH_ADDR, PH_CMD, PH_WDATA, PH_RSTART,
                              PH_RADDR, PH_RCNT, PH_RDATA, PH_STOP} phase_e;

    typedef struct packed {
        logic [4:0] proto;
        logic [7:0] addr;
        logic [7:0] cmd;
        logic [7:0] data0;
        logic [7:0] data1;
    } xfer_cfg_t;

    typedef struct packed {
        logic failed;
        logic coll;
        logic deverr;
        logic done;
    } flags_t;

    function automatic logic proto_legal(input logic [4:0] p);
        return p <= PR_BLOCK;
    endfunction

    function automatic logic count_ok(input logic [7:0] c, input int max);
        return (c != 8'd0) && (int'(c) <= max);
    endfunction

    // direction bit set and a command byte precedes the read
    function automatic logic needs_turnaround(input xfer_cfg_t c);
        return c.addr[0] && (c.proto == PR_BDATA || c.proto == PR_WDATA || c.proto == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
    import smb_host_pkg::*;
#(
    parameter int BLK_MAX = 32,
    localparam int IDX_W = $clog2(BLK_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr,
    input  logic             sw_rd,
    input  logic             sw_clr,
    input  logic [7:0]       sw_wdata,
    output logic [7:0]       sw_rdata,
    input  logic             seq_we,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic [7:0]       seq_wdata,
    output logic [7:0]       seq_rdata
);

    logic [IDX_W-1:0] sw_idx;
    logic [7:0]       ent_q [BLK_MAX];

    for (genvar i = 0; i < BLK_MAX; i++) begin : g_ent
        logic [7:0] val;
        always_ff @(posedge clk) begin
            if (rst)
                val <= '0;
            else if (seq_we && seq_idx == IDX_W'(i))
                val <= seq_wdata;
            else if (sw_wr && sw_idx == IDX_W'(i))
                val <= sw_wdata;
        end
        assign ent_q[i] = val;
    end

    always_ff @(posedge clk) begin
        if (rst || sw_clr)
            sw_idx <= '0;
        else if (sw_wr || sw_rd)
            sw_idx <= (sw_idx == IDX_W'(BLK_MAX - 1)) ? '0 : sw_idx + IDX_W'(1);
    end

    assign sw_rdata  = ent_q[sw_idx];
    assign seq_rdata = ent_q[seq_idx];

    AST_SEQ_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        seq_we |-> !sw_wr); // R9

endmodule

// File: rtl/smb_regs.sv
module smb_regs
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       go,
    output logic       kill,
    output xfer_cfg_t  cfg,
    input  logic       seq_busy,
    input  logic       fin,
    input  result_e    result,
    input  logic       wr_data0,
    input  logic       wr_data1,
    input  logic [7:0] wr_byte,
    output logic       blk_wr,
    output logic       blk_rd,
    output logic       blk_clr,
    input  logic [7:0] blk_rdata
);

    logic   go_q;
    logic   irq_en;
    flags_t flags;
    logic   busy;
    logic   ctrl_wr;
    logic   start_req;

    assign busy      = go_q | seq_busy;
    assign ctrl_wr   = reg_wr && reg_addr == REG_CTRL;
    assign start_req = ctrl_wr && !busy && reg_wdata[6];
    assign kill      = ctrl_wr && busy && reg_wdata[5];
    assign go        = go_q;
    assign blk_wr    = reg_wr && reg_addr == REG_BLOCK && !busy;
    assign blk_rd    = reg_rd && reg_addr == REG_BLOCK;
    assign blk_clr   = reg_rd && reg_addr == REG_CTRL;
    assign irq       = irq_en && (|flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            irq_en <= 1'b0;
            cfg    <= '0;
            flags  <= '0;
        end else begin
            go_q <= start_req;
            if (ctrl_wr && !busy) begin
                cfg.proto <= reg_wdata[4:0];
                irq_en    <= reg_wdata[7];
            end
            if (reg_wr && !busy) begin
                if (reg_addr == REG_CMD)   cfg.cmd   <= reg_wdata;
                if (reg_addr == REG_ADDR)  cfg.addr  <= reg_wdata;
                if (reg_addr == REG_DATA0) cfg.data0 <= reg_wdata;
                if (reg_addr == REG_DATA1) cfg.data1 <= reg_wdata;
            end
            if (wr_data0) cfg.data0 <= wr_byte;
            if (wr_data1) cfg.data1 <= wr_byte;
            if (start_req) begin
                flags <= '0;
            end else begin
                if (reg_wr && reg_addr == REG_STATUS)
                    flags <= flags & ~flags_t'(reg_wdata[4:1]);
                if (fin) begin
                    unique case (result)
                        RES_DONE:   flags.done   <= 1'b1;
                        RES_DEVERR: flags.deverr <= 1'b1;
                        RES_COLL:   flags.coll   <= 1'b1;
                        RES_FAIL:   flags.failed <= 1'b1;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_STATUS: reg_rdata = {3'b000, flags, busy};
            REG_CTRL:   reg_rdata = {irq_en, 2'b00, cfg.proto};
            REG_CMD:    reg_rdata = cfg.cmd;
            REG_ADDR:   reg_rdata = cfg.addr;
            REG_DATA0:  reg_rdata = cfg.data0;
            REG_DATA1:  reg_rdata = cfg.data1;
            REG_BLOCK:  reg_rdata = blk_rdata;
            default:    reg_rdata = 8'h00;
        endcase
    end

    AST_FIN_LEAVES_FLAG: assert property (@(posedge clk) disable iff (rst)
        fin |=> (|flags)); // R3
    AST_ONE_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $countones(flags) == 1); // R3
    AST_NO_FIN_WITHOUT_BUSY: assert property (@(posedge clk) disable iff (rst)
        fin |-> seq_busy); // R2

endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_host_pkg::*;
#(
    parameter int BLK_MAX = 32,
    localparam int IDX_W = $clog2(BLK_MAX),
    localparam int CNT_W = $clog2(BLK_MAX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             kill,
    input  xfer_cfg_t        cfg,
    output logic             busy,
    output logic             fin,
    output result_e          result,
    output logic             wr_data0,
    output logic             wr_data1,
    output logic             wr_blk,
    output logic [7:0]       wr_byte,
    output logic [IDX_W-1:0] blk_idx,
    input  logic [7:0]       blk_rbyte,
    output logic             bm_valid,
    output logic [1:0]       bm_op,
    output logic [7:0]       bm_wbyte,
    output logic             bm_last,
    input  logic             bm_done,
    input  logic             bm_ack,
    input  logic             bm_lost,
    input  logic             bm_tmo,
    input  logic [7:0]       bm_rdata
);

    typedef enum logic [1:0] {S_IDLE, S_BUS, S_FIN} state_e;

    state_e           state;
    phase_e           phase;
    logic [CNT_W-1:0] k;
    logic [CNT_W-1:0] n;
    result_e          res;
    logic             kill_pend;
    logic             rd_dir;
    logic             is_write;
    logic             k_last;
    logic             rx_ok;

    assign rd_dir   = cfg.addr[0];
    assign busy     = state != S_IDLE;
    assign fin      = state == S_FIN;
    assign result   = res;
    assign bm_valid = state == S_BUS;
    assign k_last   = (k + CNT_W'(1)) == n;
    assign is_write = phase inside {PH_ADDR, PH_CMD, PH_WDATA, PH_RADDR};
    assign bm_last  = phase == PH_RDATA && k_last;
    assign blk_idx  = IDX_W'((phase == PH_WDATA) ? k - CNT_W'(1) : k);

    always_comb begin
        unique case (phase)
            PH_START, PH_RSTART: bm_op = BM_START;
            PH_RCNT, PH_RDATA:   bm_op = BM_READ;
            PH_STOP:             bm_op = BM_STOP;
            default:             bm_op = BM_WRITE;
        endcase
    end

    always_comb begin
        unique case (phase)
            PH_ADDR:  bm_wbyte = needs_turnaround(cfg) ? {cfg.addr[7:1], 1'b0} : cfg.addr;
            PH_RADDR: bm_wbyte = {cfg.addr[7:1], 1'b1};
            PH_CMD:   bm_wbyte = cfg.cmd;
            PH_WDATA: begin
                if (k == '0)                 bm_wbyte = cfg.data0;
                else if (cfg.proto == PR_BLOCK) bm_wbyte = blk_rbyte;
                else                         bm_wbyte = cfg.data1;
            end
            default:  bm_wbyte = 8'h00;
        endcase
    end

    // received bytes are kept unless the bus was lost or timed out
    assign rx_ok    = state == S_BUS && bm_done && !bm_lost && !bm_tmo;
    assign wr_byte  = bm_rdata;
    assign wr_data0 = rx_ok && (phase == PH_RCNT || (phase == PH_RDATA && cfg.proto != PR_BLOCK && k == '0));
    assign wr_data1 = rx_ok && phase == PH_RDATA && cfg.proto == PR_WDATA && k == CNT_W'(1);
    assign wr_blk   = rx_ok && phase == PH_RDATA && cfg.proto == PR_BLOCK;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            phase     <= PH_START;
            k         <= '0;
            n         <= '0;
            res       <= RES_DONE;
            kill_pend <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (go) begin
                    kill_pend <= kill;
                    res       <= RES_DONE;
                    k         <= '0;
                    phase     <= PH_START;
                    if (cfg.proto == PR_WDATA)      n <= CNT_W'(2);
                    else if (cfg.proto == PR_BLOCK) n <= CNT_W'(cfg.data0) + CNT_W'(1);
                    else                            n <= CNT_W'(1);
                    if (!proto_legal(cfg.proto)) begin
                        res   <= RES_DEVERR;
                        state <= S_FIN;
                    end else if (cfg.proto == PR_BLOCK && !rd_dir && !count_ok(cfg.data0, BLK_MAX)) begin
                        res   <= RES_DEVERR;
                        state <= S_FIN;
                    end else begin
                        state <= S_BUS;
                    end
                end
                S_BUS: begin
                    if (kill) kill_pend <= 1'b1;
                    if (bm_done) begin
                        if (phase == PH_STOP) begin
                            if (kill_pend && res == RES_DONE) res <= RES_FAIL;
                            state <= S_FIN;
                        end else if (bm_lost) begin
                            res   <= RES_COLL;
                            state <= S_FIN;
                        end else if (bm_tmo || (is_write && !bm_ack)) begin
                            res   <= RES_DEVERR;
                            phase <= PH_STOP;
                        end else if (kill_pend) begin
                            res   <= RES_FAIL;
                            phase <= PH_STOP;
                        end else begin
                            unique case (phase)
                                PH_START: phase <= PH_ADDR;
                                PH_ADDR: begin
                                    if (cfg.proto == PR_QUICK)                phase <= PH_STOP;
                                    else if (cfg.proto == PR_BYTE && rd_dir)  phase <= PH_RDATA;
                                    else                                      phase <= PH_CMD;
                                end
                                PH_CMD: begin
                                    if (cfg.proto == PR_BYTE) phase <= PH_STOP;
                                    else if (rd_dir)          phase <= PH_RSTART;
                                    else                      phase <= PH_WDATA;
                                end
                                PH_RSTART: phase <= PH_RADDR;
                                PH_RADDR:  phase <= (cfg.proto == PR_BLOCK) ? PH_RCNT : PH_RDATA;
                                PH_RCNT: begin
                                    if (count_ok(bm_rdata, BLK_MAX)) begin
                                        n     <= CNT_W'(bm_rdata);
                                        phase <= PH_RDATA;
                                    end else begin
                                        res   <= RES_DEVERR;
                                        phase <= PH_STOP;
                                    end
                                end
                                PH_WDATA, PH_RDATA: begin
                                    if (k_last) phase <= PH_STOP;
                                    else        k     <= k + CNT_W'(1);
                                end
                                default: phase <= PH_STOP;
                            endcase
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        go |-> state == S_IDLE); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        bm_valid && !bm_done |=> bm_valid && $stable(bm_op) && $stable(bm_wbyte)); // R4
    AST_COLL_NO_STOP: assert property (@(posedge clk) disable iff (rst)
        bm_valid && bm_done && bm_lost && bm_op != BM_STOP |=> !bm_valid); // R11
    AST_NO_CMD_WHEN_KILLED: assert property (@(posedge clk) disable iff (rst)
        bm_valid && bm_done && kill_pend && bm_op != BM_STOP |=> !bm_valid || bm_op == BM_STOP); // R13

endmodule

// File: rtl/smb_host_ctrl.sv
module smb_host_ctrl
    import smb_host_pkg::*;
#(
    parameter int BLK_MAX = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       bm_valid,
    output logic [1:0] bm_op,
    output logic [7:0] bm_wbyte,
    output logic       bm_last,
    input  logic       bm_done,
    input  logic       bm_ack,
    input  logic       bm_lost,
    input  logic       bm_tmo,
    input  logic [7:0] bm_rdata
);

    localparam int IDX_W = $clog2(BLK_MAX);

    logic             go, kill, seq_busy, fin;
    result_e          result;
    xfer_cfg_t        cfg;
    logic             wr_data0, wr_data1, wr_blk;
    logic [7:0]       wr_byte;
    logic             blk_wr, blk_rd, blk_clr;
    logic [7:0]       blk_sw_rdata, blk_seq_rdata;
    logic [IDX_W-1:0] blk_idx;

    smb_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .go(go), .kill(kill), .cfg(cfg), .seq_busy(seq_busy),
        .fin(fin), .result(result),
        .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_byte(wr_byte),
        .blk_wr(blk_wr), .blk_rd(blk_rd), .blk_clr(blk_clr),
        .blk_rdata(blk_sw_rdata)
    );

    smb_blkbuf #(.BLK_MAX(BLK_MAX)) u_buf (
        .clk(clk), .rst(rst),
        .sw_wr(blk_wr), .sw_rd(blk_rd), .sw_clr(blk_clr),
        .sw_wdata(reg_wdata), .sw_rdata(blk_sw_rdata),
        .seq_we(wr_blk), .seq_idx(blk_idx), .seq_wdata(wr_byte),
        .seq_rdata(blk_seq_rdata)
    );

    smb_seq #(.BLK_MAX(BLK_MAX)) u_seq (
        .clk(clk), .rst(rst), .go(go), .kill(kill), .cfg(cfg),
        .busy(seq_busy), .fin(fin), .result(result),
        .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_blk(wr_blk),
        .wr_byte(wr_byte), .blk_idx(blk_idx), .blk_rbyte(blk_seq_rdata),
        .bm_valid(bm_valid), .bm_op(bm_op), .bm_wbyte(bm_wbyte),
        .bm_last(bm_last), .bm_done(bm_done), .bm_ack(bm_ack),
        .bm_lost(bm_lost), .bm_tmo(bm_tmo), .bm_rdata(bm_rdata)
    );

endmodule

// File: tb/test_smb_host_ctrl.sv
module test_smb_host_ctrl;
    import smb_host_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, bm_valid, bm_last;
    logic [1:0] bm_op;
    logic [7:0] bm_wbyte;
    logic       bm_done = 1'b0, bm_ack = 1'b0, bm_lost = 1'b0, bm_tmo = 1'b0;
    logic [7:0] bm_rdata = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    smb_host_ctrl i_smb_host_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bm_valid(bm_valid), .bm_op(bm_op), .bm_wbyte(bm_wbyte),
        .bm_last(bm_last), .bm_done(bm_done), .bm_ack(bm_ack),
        .bm_lost(bm_lost), .bm_tmo(bm_tmo), .bm_rdata(bm_rdata)
    );

    // bus-master model: answers each primitive on its second cycle
    logic [1:0] lg_op [64];
    logic [7:0] lg_byte [64];
    logic       lg_last [64];
    logic [1:0] ex_op [64];
    logic [7:0] ex_byte [64];
    logic       ex_last [64];
    logic [7:0] rdq [64];
    int nlog = 0, nexp = 0, rdp = 0, cnt = 0;
    int nack_at = -1, lost_at = -1, tmo_at = -1;

    always @(posedge clk) begin
        if (bm_done) begin
            bm_done <= 1'b0;
        end else if (bm_valid) begin
            if (cnt == 1) begin
                cnt = 0;
                lg_op[nlog]   = bm_op;
                lg_byte[nlog] = bm_wbyte;
                lg_last[nlog] = bm_last;
                bm_ack  <= (nlog != nack_at);
                bm_lost <= (nlog == lost_at);
                bm_tmo  <= (nlog == tmo_at);
                if (bm_op == 2'd2) begin
                    bm_rdata <= rdq[rdp];
                    rdp = rdp + 1;
                end
                bm_done <= 1'b1;
                nlog = nlog + 1;
            end else begin
                cnt = cnt + 1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic fresh();
        nlog = 0; nexp = 0; rdp = 0;
        nack_at = -1; lost_at = -1; tmo_at = -1;
    endtask

    task automatic ex(input logic [1:0] op, input logic [7:0] b, input logic last);
        ex_op[nexp] = op; ex_byte[nexp] = b; ex_last[nexp] = last;
        nexp++;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(REG_STATUS, s);
            if (!s[0]) return;
        end
        chk({req, " stuck busy"}, 1, 0);
    endtask

    task automatic run(input logic [7:0] ctrl, input string req);
        logic [7:0] s;
        wr(REG_CTRL, ctrl);
        rd(REG_STATUS, s);
        chk({req, " R2 busy after start"}, s[0], 1'b1);
        wait_idle(req);
    endtask

    task automatic check_log(input string req);
        int ok = (nlog == nexp);
        for (int i = 0; i < nexp && i < nlog; i++) begin
            if (lg_op[i] != ex_op[i]) ok = 0;
            if (ex_op[i] == 2'd1 && lg_byte[i] != ex_byte[i]) ok = 0;
            if (ex_op[i] == 2'd2 && lg_last[i] != ex_last[i]) ok = 0;
        end
        if (!ok) for (int i = 0; i < nlog; i++)
            $display("  got op=%0d byte=%h last=%0d", lg_op[i], lg_byte[i], lg_last[i]);
        chk({req, " primitive sequence (count match=1)"}, ok, 1);
    endtask

    task automatic expect_status(input string req, input logic [7:0] exp);
        logic [7:0] s;
        rd(REG_STATUS, s);
        chk({req, " status"}, s, exp);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset register value", v, 0);
        end
        chk("R1 reset irq", irq, 0);
        chk("R1 reset bm_valid", bm_valid, 0);
    endtask

    task automatic t_quick();
        fresh();
        wr(REG_ADDR, 8'hA1);
        run({3'b010, PR_QUICK}, "R4");
        ex(0, 0, 0); ex(1, 8'hA1, 0); ex(3, 0, 0);
        check_log("R4 quick");
        expect_status("R3 done only", 8'h02);
        chk("R14 no irq when disabled", irq, 0);
    endtask

    task automatic t_send_recv();
        logic [7:0] v;
        fresh();
        wr(REG_ADDR, 8'h50); wr(REG_CMD, 8'h3C);
        run({3'b010, PR_BYTE}, "R5");
        ex(0, 0, 0); ex(1, 8'h50, 0); ex(1, 8'h3C, 0); ex(3, 0, 0);
        check_log("R5 send byte");
        fresh();
        rdq[0] = 8'h9E;
        wr(REG_ADDR, 8'h51);
        run({3'b010, PR_BYTE}, "R5");
        ex(0, 0, 0); ex(1, 8'h51, 0); ex(2, 0, 1); ex(3, 0, 0);
        check_log("R5 receive byte");
        rd(REG_DATA0, v);
        chk("R5 received byte in data0", v, 8'h9E);
    endtask

    task automatic t_word();
        logic [7:0] v;
        fresh();
        wr(REG_ADDR, 8'h40); wr(REG_CMD, 8'h11); wr(REG_DATA0, 8'h22); wr(REG_DATA1, 8'h33);
        run({3'b010, PR_WDATA}, "R6");
        ex(0, 0, 0); ex(1, 8'h40, 0); ex(1, 8'h11, 0); ex(1, 8'h22, 0); ex(1, 8'h33, 0); ex(3, 0, 0);
        check_log("R6 word write");
        fresh();
        rdq[0] = 8'h5A; rdq[1] = 8'hA5;
        wr(REG_ADDR, 8'h41); wr(REG_CMD, 8'h07);
        run({3'b010, PR_WDATA}, "R6");
        ex(0, 0, 0); ex(1, 8'h40, 0); ex(1, 8'h07, 0); ex(0, 0, 0); ex(1, 8'h41, 0);
        ex(2, 0, 0); ex(2, 0, 1); ex(3, 0, 0);
        check_log("R6 word read");
        rd(REG_DATA0, v); chk("R6 low byte in data0", v, 8'h5A);
        rd(REG_DATA1, v); chk("R6 high byte in data1", v, 8'hA5);
        fresh();
        rdq[0] = 8'h6C;
        wr(REG_CMD, 8'h09);
        run({3'b010, PR_BDATA}, "R6");
        ex(0, 0, 0); ex(1, 8'h40, 0); ex(1, 8'h09, 0); ex(0, 0, 0); ex(1, 8'h41, 0);
        ex(2, 0, 1); ex(3, 0, 0);
        check_log("R6 byte read");
        rd(REG_DATA0, v); chk("R6 byte read data0", v, 8'h6C);
    endtask

    task automatic t_block();
        logic [7:0] v;
        fresh();
        rd(REG_CTRL, v);
        wr(REG_BLOCK, 8'hB0); wr(REG_BLOCK, 8'hB1); wr(REG_BLOCK, 8'hB2);
        rd(REG_CTRL, v);
        rd(REG_BLOCK, v); chk("R9 index reset by control read", v, 8'hB0);
        rd(REG_BLOCK, v); chk("R9 index advances", v, 8'hB1);
        wr(REG_ADDR, 8'h60); wr(REG_CMD, 8'h77); wr(REG_DATA0, 8'd3);
        run({3'b010, PR_BLOCK}, "R7");
        ex(0, 0, 0); ex(1, 8'h60, 0); ex(1, 8'h77, 0); ex(1, 8'h03, 0);
        ex(1, 8'hB0, 0); ex(1, 8'hB1, 0); ex(1, 8'hB2, 0); ex(3, 0, 0);
        check_log("R7 block write");
        expect_status("R7 block write done", 8'h02);
        fresh();
        wr(REG_DATA0, 8'd0);
        run({3'b010, PR_BLOCK}, "R7");
        chk("R7 zero count no bus activity", nlog, 0);
        expect_status("R7 zero count", 8'h04);
        wr(REG_DATA0, 8'd33);
        run({3'b010, PR_BLOCK}, "R7");
        chk("R7 count 33 no bus activity", nlog, 0);
        expect_status("R7 count 33", 8'h04);
        fresh();
        rdq[0] = 8'd4; rdq[1] = 8'hC0; rdq[2] = 8'hC1; rdq[3] = 8'hC2; rdq[4] = 8'hC3;
        wr(REG_ADDR, 8'h61); wr(REG_CMD, 8'h78);
        run({3'b010, PR_BLOCK}, "R8");
        ex(0, 0, 0); ex(1, 8'h60, 0); ex(1, 8'h78, 0); ex(0, 0, 0); ex(1, 8'h61, 0);
        ex(2, 0, 0); ex(2, 0, 0); ex(2, 0, 0); ex(2, 0, 0); ex(2, 0, 1); ex(3, 0, 0);
        check_log("R8 block read");
        rd(REG_DATA0, v); chk("R8 count in data0", v, 8'd4);
        rd(REG_CTRL, v);
        for (int i = 0; i < 4; i++) begin
            rd(REG_BLOCK, v);
            chk("R8 R9 block read payload", v, 8'hC0 + 8'(i));
        end
        fresh();
        rdq[0] = 8'd33;
        run({3'b010, PR_BLOCK}, "R8");
        ex(0, 0, 0); ex(1, 8'h60, 0); ex(1, 8'h78, 0); ex(0, 0, 0); ex(1, 8'h61, 0);
        ex(2, 0, 0); ex(3, 0, 0);
        check_log("R8 bad count stops");
        expect_status("R8 bad count", 8'h04);
    endtask

    task automatic t_errors();
        fresh();
        nack_at = 1;
        wr(REG_ADDR, 8'h40); wr(REG_CMD, 8'h01); wr(REG_DATA0, 8'h02);
        run({3'b010, PR_BDATA}, "R10");
        ex(0, 0, 0); ex(1, 8'h40, 0); ex(3, 0, 0);
        check_log("R10 nack on address");
        expect_status("R10 nack", 8'h04);
        fresh();
        tmo_at = 2;
        run({3'b010, PR_BDATA}, "R10");
        ex(0, 0, 0); ex(1, 8'h40, 0); ex(1, 8'h01, 0); ex(3, 0, 0);
        check_log("R10 timeout");
        expect_status("R10 timeout", 8'h04);
        fresh();
        lost_at = 1;
        run({3'b010, PR_BDATA}, "R11");
        ex(0, 0, 0); ex(1, 8'h40, 0);
        check_log("R11 lost arbitration no stop");
        expect_status("R11 collision", 8'h08);
        fresh();
        run({3'b010, 5'd5}, "R12");
        chk("R12 code 5 no bus activity", nlog, 0);
        expect_status("R12 code 5", 8'h04);
        run({3'b010, 5'd31}, "R12");
        chk("R12 code 31 no bus activity", nlog, 0);
        expect_status("R12 code 31", 8'h04);
    endtask

    task automatic t_kill();
        fresh();
        wr(REG_ADDR, 8'h40);
        wr(REG_CTRL, {3'b010, PR_WDATA});
        wr(REG_CTRL, 8'h20);
        wait_idle("R13");
        ex(0, 0, 0); ex(3, 0, 0);
        check_log("R13 kill issues stop");
        expect_status("R13 failed", 8'h10);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        fresh();
        wr(REG_ADDR, 8'hA1);
        wr(REG_CTRL, {3'b010, PR_QUICK});
        wr(REG_ADDR, 8'h33);
        wr(REG_CTRL, {3'b010, PR_WDATA});
        wait_idle("R2");
        ex(0, 0, 0); ex(1, 8'hA1, 0); ex(3, 0, 0);
        check_log("R2 start while busy ignored");
        rd(REG_ADDR, v); chk("R2 address write while busy ignored", v, 8'hA1);
        rd(REG_CTRL, v); chk("R2 control write while busy ignored", v, 8'h00);
    endtask

    task automatic t_irq();
        fresh();
        run({3'b110, PR_QUICK}, "R14");
        chk("R14 irq with done and enable", irq, 1);
        wr(REG_STATUS, 8'h04);
        expect_status("R3 clearing other bit keeps done", 8'h02);
        chk("R14 irq still set", irq, 1);
        wr(REG_STATUS, 8'h02);
        expect_status("R3 write one clears done", 8'h00);
        chk("R14 irq drops with flags", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_quick();
        t_send_recv();
        t_word();
        t_block();
        t_errors();
        t_kill();
        t_busy_ignore();
        t_irq();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule